// File: doc/BRIEF.md
# CAN Identifier Acceptance Filter

This block decides whether a received CAN frame identifier is of interest. It holds a set of programmable filter banks. Each bank owns two 32-bit words. In mask mode the first word is the expected identifier and the second is a bit mask: a mask bit of 1 forces a compare, and a mask bit of 0 ignores that position. In list mode both words are exact identifiers, and either one may match. A bit of 0 in an identifier word stands for a dominant level and a bit of 1 for a recessive level. The same 32-bit layout applies to identifier words and mask words.

Software loads the words through a register-style write port. A control write sets three things in one step: the global init flag, the per-bank activation bits and the per-bank mode bits. A word write is accepted only if its target bank is inactive or the init flag is set. Otherwise the write is dropped, so a live filter cannot be corrupted. For each identifier strobe the block reports one clock later whether any active bank matched. It also reports the lowest-numbered matching bank.

Top module: `can_id_filter`

## Requirements
- R1: After reset the init flag is set, every bank is inactive, every bank is in mask mode, `hit_valid` and `hit_accept` are 0, and no identifier is accepted until a bank is activated.
- R2: A word write (`cfg_wr_en`=1) to a bank below NUM_BANKS updates that bank's word 1 (`cfg_wr_sel`=0) or word 2 (`cfg_wr_sel`=1) at the next clock edge when the bank's activation bit is 0 or the init flag is 1.
- R3: A word write to a bank whose activation bit is 1 while the init flag is 0 leaves the stored word unchanged.
- R4: A bank whose mode bit is 0 (mask mode) matches when ((id XOR word1) AND word2) equals 0.
- R5: A bank whose mode bit is 1 (list mode) matches when the id equals word1 or equals word2.
- R6: A bank whose activation bit is 0 never produces a match.
- R7: When several active banks match, `hit_bank` gives the lowest-numbered one, and `hit_accept` is 1.
- R8: `hit_valid`, `hit_accept` and `hit_bank` are registered. They reflect the `id_valid`/`id_in` sampled at the previous clock edge. When `id_valid` was 0, `hit_valid` and `hit_accept` are 0.
- R9: A control write (`ctl_wr_en`=1) loads `ctl_init`, `ctl_active` (bit i for bank i) and `ctl_mode` (bit i for bank i) at the next edge. A word write in the same cycle is gated by the control values held before that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_wr_en | input | 1 | Filter word write strobe |
| cfg_wr_bank | input | IDX_W (4) | Target bank of the word write |
| cfg_wr_sel | input | 1 | 0 selects word 1, 1 selects word 2 |
| cfg_wr_data | input | ID_W (32) | Word write data |
| ctl_wr_en | input | 1 | Control write strobe |
| ctl_init | input | 1 | New init flag |
| ctl_active | input | NUM_BANKS (14) | New activation bits |
| ctl_mode | input | NUM_BANKS (14) | New mode bits (0 mask, 1 list) |
| id_valid | input | 1 | Incoming identifier strobe |
| id_in | input | ID_W (32) | Incoming identifier |
| hit_valid | output | 1 | Result strobe, one cycle after `id_valid` |
| hit_accept | output | 1 | An active bank matched |
| hit_bank | output | IDX_W (4) | Lowest matching bank, 0 when none |

## Verification
The match result is due exactly one clock edge after the edge that samples `id_valid`. The bench raises the strobe on a falling edge, drops it on the next falling edge, and reads `hit_valid`, `hit_accept` and `hit_bank` at that second falling edge. Word writes and control writes take effect at the edge after they are driven. A probe issued after the write task returns therefore observes the updated state, or the unchanged state when the write was blocked. Expected results come from a bench model that applies the gating and match rules in the order given by the requirements.

// File: rtl/can_filt_pkg.sv
// Shared encodings for the identifier acceptance filter.
// Assumes: mode and word-select are single-bit codes as listed below.
package can_filt_pkg;
    typedef enum logic {
        MODE_MASK = 1'b0,
        MODE_LIST = 1'b1
    } filt_mode_e;

    typedef enum logic {
        SEL_WORD1 = 1'b0,
        SEL_WORD2 = 1'b1
    } word_sel_e;
endpackage

// File: rtl/can_filt_bank.sv
// One filter bank: two stored words plus the mask/list comparator.
// Assumes: wr_en is already qualified by bank address and write permission;
// stored words carry no reset, their value is undefined until written.
module can_filt_bank
    import can_filt_pkg::*;
#(
    parameter int ID_W = 32
) (
    input  logic            clk,
    input  logic            wr_en,
    input  logic            wr_sel,
    input  logic [ID_W-1:0] wr_data,
    input  logic            list_mode,
    input  logic            active,
    input  logic [ID_W-1:0] id_in,
    output logic            match,
    output logic [ID_W-1:0] word1_o
);
    logic [ID_W-1:0] word1_q;
    logic [ID_W-1:0] word2_q;
    filt_mode_e      mode;
    word_sel_e       sel;

    assign mode = filt_mode_e'(list_mode);
    assign sel  = word_sel_e'(wr_sel);

    // Store the selected word when the write is permitted.
    always_ff @(posedge clk) begin
        if (wr_en) begin
            if (sel == SEL_WORD2) begin
                word2_q <= wr_data;
            end else begin
                word1_q <= wr_data;
            end
        end
    end

    // Compare the incoming identifier according to the bank mode.
    always_comb begin
        logic hit;
        if (mode == MODE_LIST) begin
            hit = (id_in == word1_q) || (id_in == word2_q);
        end else begin
            hit = ((id_in ^ word1_q) & word2_q) == '0;
        end
        match = active && hit;
    end

    assign word1_o = word1_q;
endmodule

// File: rtl/can_filt_prio.sv
// Fixed-priority encoder: the lowest set request wins.
// Assumes: NB fits in IDX_W bits; idx is 0 when no request is set.
module can_filt_prio #(
    parameter int NB    = 14,
    parameter int IDX_W = 4
) (
    input  logic [NB-1:0]    req,
    output logic             any,
    output logic [IDX_W-1:0] idx
);
    // Scan from the top so the lowest request is written last.
    always_comb begin
        idx = '0;
        for (int i = NB - 1; i >= 0; i--) begin
            if (req[i]) begin
                idx = IDX_W'(i);
            end
        end
        any = |req;
    end
endmodule

// File: rtl/can_id_filter.sv
// Identifier acceptance filter top: control registers, write gating,
// a bank per generate slot, priority select and registered result.
// Assumes: synchronous active-low reset; writes to bank numbers at or
// above NUM_BANKS are dropped.
module can_id_filter
    import can_filt_pkg::*;
#(
    parameter int NUM_BANKS = 14,
    parameter int ID_W      = 32,
    localparam int IDX_W    = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cfg_wr_en,
    input  logic [IDX_W-1:0]     cfg_wr_bank,
    input  logic                 cfg_wr_sel,
    input  logic [ID_W-1:0]      cfg_wr_data,
    input  logic                 ctl_wr_en,
    input  logic                 ctl_init,
    input  logic [NUM_BANKS-1:0] ctl_active,
    input  logic [NUM_BANKS-1:0] ctl_mode,
    input  logic                 id_valid,
    input  logic [ID_W-1:0]      id_in,
    output logic                 hit_valid,
    output logic                 hit_accept,
    output logic [IDX_W-1:0]     hit_bank
);
    logic                      init_q;
    logic [NUM_BANKS-1:0]      act_q;
    logic [NUM_BANKS-1:0]      mode_q;
    logic [NUM_BANKS-1:0]      bank_we;
    logic [NUM_BANKS-1:0]      bank_match;
    logic [NUM_BANKS*ID_W-1:0] w1_flat;
    logic                      any_match;
    logic [IDX_W-1:0]          win_idx;

    // Control flags: init set, banks inactive and in mask mode after reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            init_q <= 1'b1;
            act_q  <= '0;
            mode_q <= {NUM_BANKS{MODE_MASK}};
        end else if (ctl_wr_en) begin
            init_q <= ctl_init;
            act_q  <= ctl_active;
            mode_q <= ctl_mode;
        end
    end

    for (genvar g = 0; g < NUM_BANKS; g++) begin : g_bank
        logic [ID_W-1:0] w1;

        // Permit a write only to an idle bank or while init is set.
        assign bank_we[g] = cfg_wr_en && (cfg_wr_bank == IDX_W'(g))
                            && (init_q || !act_q[g]);

        can_filt_bank #(.ID_W(ID_W)) u_bank (
            .clk       (clk),
            .wr_en     (bank_we[g]),
            .wr_sel    (cfg_wr_sel),
            .wr_data   (cfg_wr_data),
            .list_mode (mode_q[g]),
            .active    (act_q[g]),
            .id_in     (id_in),
            .match     (bank_match[g]),
            .word1_o   (w1)
        );

        assign w1_flat[g*ID_W +: ID_W] = w1;
    end

    can_filt_prio #(.NB(NUM_BANKS), .IDX_W(IDX_W)) u_prio (
        .req (bank_match),
        .any (any_match),
        .idx (win_idx)
    );

    // Register the verdict one clock after the identifier strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hit_valid  <= 1'b0;
            hit_accept <= 1'b0;
            hit_bank   <= '0;
        end else begin
            hit_valid  <= id_valid;
            hit_accept <= id_valid && any_match;
            hit_bank   <= (id_valid && any_match) ? win_idx : '0;
        end
    end
endmodule

// File: rtl/can_id_filter_chk.sv
// Checker for the acceptance filter, bound to every can_id_filter instance.
// Assumes: sees the control flags and the flattened word-1 storage.
module can_id_filter_chk #(
    parameter int NUM_BANKS = 14,
    parameter int ID_W      = 32,
    parameter int IDX_W     = 4
) (
    input logic                      clk,
    input logic                      rst_n,
    input logic                      cfg_wr_en,
    input logic [IDX_W-1:0]          cfg_wr_bank,
    input logic                      cfg_wr_sel,
    input logic [ID_W-1:0]           cfg_wr_data,
    input logic                      init_q,
    input logic [NUM_BANKS-1:0]      act_q,
    input logic                      id_valid,
    input logic                      hit_valid,
    input logic                      hit_accept,
    input logic [IDX_W-1:0]          hit_bank,
    input logic [NUM_BANKS*ID_W-1:0] w1_flat
);
    logic                 in_range;
    logic                 sel_act;
    logic [ID_W-1:0]      sel_word;
    logic                 take_d;
    logic                 block_d;
    logic [IDX_W-1:0]     bank_d;
    logic [ID_W-1:0]      data_d;
    logic [ID_W-1:0]      old_d;
    logic [NUM_BANKS-1:0] act_d;
    logic [ID_W-1:0]      cur_word;

    assign in_range = int'(cfg_wr_bank) < NUM_BANKS;
    assign sel_act  = |((act_q >> cfg_wr_bank) & NUM_BANKS'(1));
    assign sel_word = ID_W'(w1_flat >> (int'(cfg_wr_bank) * ID_W));
    assign cur_word = ID_W'(w1_flat >> (int'(bank_d) * ID_W));

    // Capture word-1 write attempts and control state for next-cycle checks.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            take_d  <= 1'b0;
            block_d <= 1'b0;
            bank_d  <= '0;
            data_d  <= '0;
            old_d   <= '0;
            act_d   <= '0;
        end else begin
            take_d  <= cfg_wr_en && !cfg_wr_sel && in_range && (init_q || !sel_act);
            block_d <= cfg_wr_en && in_range && !init_q && sel_act;
            bank_d  <= cfg_wr_bank;
            data_d  <= cfg_wr_data;
            old_d   <= sel_word;
            act_d   <= act_q;
        end
    end

    // R2
    write_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
        take_d |-> cur_word == data_d);

    // R3
    write_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        block_d |-> cur_word == old_d);

    // R6
    active_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hit_accept |-> |((act_d >> hit_bank) & NUM_BANKS'(1)));

    // R7
    bank_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hit_accept |-> int'(hit_bank) < NUM_BANKS);

    // R8
    valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        id_valid |=> hit_valid);

    // R8
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !id_valid |=> !hit_valid && !hit_accept);
endmodule

bind can_id_filter can_id_filter_chk #(
    .NUM_BANKS (NUM_BANKS),
    .ID_W      (ID_W),
    .IDX_W     (IDX_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .cfg_wr_en   (cfg_wr_en),
    .cfg_wr_bank (cfg_wr_bank),
    .cfg_wr_sel  (cfg_wr_sel),
    .cfg_wr_data (cfg_wr_data),
    .init_q      (init_q),
    .act_q       (act_q),
    .id_valid    (id_valid),
    .hit_valid   (hit_valid),
    .hit_accept  (hit_accept),
    .hit_bank    (hit_bank),
    .w1_flat     (w1_flat)
);

// File: tb/can_id_filter_tb_top.sv
// Bench for can_id_filter: directed corner cases, then seeded random traffic
// checked against a behavioural model of the requirements.
module can_id_filter_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int NB         = 14;
    localparam int IW         = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cfg_wr_en = 1'b0;
    logic [IW-1:0] cfg_wr_bank = '0;
    logic          cfg_wr_sel = 1'b0;
    logic [31:0]   cfg_wr_data = '0;
    logic          ctl_wr_en = 1'b0;
    logic          ctl_init = 1'b0;
    logic [NB-1:0] ctl_active = '0;
    logic [NB-1:0] ctl_mode = '0;
    logic          id_valid = 1'b0;
    logic [31:0]   id_in = '0;
    logic          hit_valid;
    logic          hit_accept;
    logic [IW-1:0] hit_bank;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    logic [31:0]   m_w1 [NB];
    logic [31:0]   m_w2 [NB];
    logic [NB-1:0] m_act;
    logic [NB-1:0] m_mode;
    logic          m_init;

    always #(CLK_PERIOD/2) clk = ~clk;

    can_id_filter dut_i (
        .clk(clk), .rst_n(rst_n),
        .cfg_wr_en(cfg_wr_en), .cfg_wr_bank(cfg_wr_bank),
        .cfg_wr_sel(cfg_wr_sel), .cfg_wr_data(cfg_wr_data),
        .ctl_wr_en(ctl_wr_en), .ctl_init(ctl_init),
        .ctl_active(ctl_active), .ctl_mode(ctl_mode),
        .id_valid(id_valid), .id_in(id_in),
        .hit_valid(hit_valid), .hit_accept(hit_accept), .hit_bank(hit_bank)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // Expected verdict: lowest active bank matching under its mode (R4..R7).
    function automatic void model_hit(input logic [31:0] id, output logic acc, output logic [IW-1:0] bk);
        acc = 1'b0;
        bk  = '0;
        for (int i = 0; i < NB; i++) begin
            logic m;
            if (m_mode[i]) m = (id == m_w1[i]) || (id == m_w2[i]);
            else           m = ((id ^ m_w1[i]) & m_w2[i]) == 32'h0;
            if (m_act[i] && m && !acc) begin
                acc = 1'b1;
                bk  = IW'(i);
            end
        end
    endfunction

    task automatic wr_word(input int bank, input logic sel, input logic [31:0] data);
        @(negedge clk);
        cfg_wr_en = 1'b1; cfg_wr_bank = IW'(bank); cfg_wr_sel = sel; cfg_wr_data = data;
        @(negedge clk);
        cfg_wr_en = 1'b0;
        if (bank < NB && (m_init || !m_act[bank])) begin
            if (sel) m_w2[bank] = data;
            else     m_w1[bank] = data;
        end
    endtask

    task automatic wr_ctl(input logic init, input logic [NB-1:0] act, input logic [NB-1:0] mode);
        @(negedge clk);
        ctl_wr_en = 1'b1; ctl_init = init; ctl_active = act; ctl_mode = mode;
        @(negedge clk);
        ctl_wr_en = 1'b0;
        m_init = init; m_act = act; m_mode = mode;
    endtask

    task automatic probe(input logic [31:0] id, input string req);
        logic          e_acc;
        logic [IW-1:0] e_bk;
        model_hit(id, e_acc, e_bk);
        @(negedge clk);
        id_valid = 1'b1; id_in = id;
        @(negedge clk);
        id_valid = 1'b0;
        check({req, " valid"},  32'(hit_valid), 32'd1);
        check({req, " accept"}, 32'(hit_accept), 32'(e_acc));
        check({req, " bank"},   32'(hit_bank), 32'(e_bk));
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    endtask

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            finish_run();
        end
    end

    initial begin
        void'($urandom(32'd24680));
        for (int i = 0; i < NB; i++) begin m_w1[i] = '0; m_w2[i] = '0; end
        m_act = '0; m_mode = '0; m_init = 1'b1;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: quiet outputs after reset, and nothing is accepted
        check("R1 hit_valid", 32'(hit_valid), 32'd0);
        check("R1 hit_accept", 32'(hit_accept), 32'd0);
        probe(32'h0000_0000, "R1 idle banks");

        // R2, R9: load banks while init is set
        wr_word(0, 1'b0, 32'h0000_1230); wr_word(0, 1'b1, 32'hFFFF_FFF0);
        wr_word(3, 1'b0, 32'hAAAA_0001); wr_word(3, 1'b1, 32'h5555_0002);
        wr_word(5, 1'b0, 32'h0000_1234); wr_word(5, 1'b1, 32'hFFFF_FFFF);
        wr_ctl(1'b0, NB'(14'b00_0000_0010_1001), NB'(14'b00_0000_0000_1000));

        probe(32'h0000_1237, "R4 mask dont-care bits");
        probe(32'h0000_1244, "R4 masked bit differs");
        probe(32'h0000_1234, "R7 lowest of bank0 and bank5");
        probe(32'h5555_0002, "R5 list word2");
        probe(32'hAAAA_0001, "R5 list word1");
        probe(32'hAAAA_0002, "R5 list miss");

        // R3: word write to an active bank with init clear is dropped
        wr_word(0, 1'b0, 32'h0000_9990);
        probe(32'h0000_1234, "R3 blocked write keeps bank0");
        probe(32'h0000_9990, "R3 blocked value absent");

        // R6: inactive bank holds a matching word but stays silent
        wr_word(7, 1'b0, 32'h0000_7777); wr_word(7, 1'b1, 32'hFFFF_FFFF);
        probe(32'h0000_7777, "R6 inactive bank7");
        wr_ctl(1'b0, NB'(14'b00_0000_1010_1001), NB'(14'b00_0000_0000_1000));
        probe(32'h0000_7777, "R2 inactive-bank write then activate");

        // R2, R9: init set re-opens writes to active banks
        wr_ctl(1'b1, m_act, m_mode);
        wr_word(0, 1'b0, 32'h0000_9990);
        wr_ctl(1'b0, m_act, m_mode);
        probe(32'h0000_9995, "R2 write under init");
        probe(32'h0000_1234, "R7 bank5 after bank0 change");

        // R8: no strobe gives no result
        @(negedge clk);
        check("R8 no strobe valid", 32'(hit_valid), 32'd0);
        check("R8 no strobe accept", 32'(hit_accept), 32'd0);

        // Random phase: reload all banks, then mixed traffic
        wr_ctl(1'b1, '0, '0);
        for (int i = 0; i < NB; i++) begin
            wr_word(i, 1'b0, $urandom);
            wr_word(i, 1'b1, $urandom | 32'hFFFF_0000);
        end
        wr_ctl(1'b0, NB'($urandom), NB'($urandom));
        for (int it = 0; it < 400; it++) begin
            int op = int'($urandom_range(0, 9));
            int b  = int'($urandom_range(0, NB - 1));
            if (op == 0) begin
                wr_word(b, 1'($urandom), $urandom);
            end else if (op == 1) begin
                wr_ctl(1'($urandom_range(0, 3) == 0), NB'($urandom), NB'($urandom));
            end else if (op < 6) begin
                logic [31:0] id;
                if (m_mode[b]) id = 1'($urandom) ? m_w2[b] : m_w1[b];
                else           id = m_w1[b] ^ ($urandom & ~m_w2[b]);
                probe(id, "R4 R5 R7 random targeted");
            end else begin
                probe($urandom, "R6 random id");
            end
        end

        done = 1'b1;
        finish_run();
    end
endmodule